// File: doc/BRIEF.md
# Inter-Core Message and Interrupt Mailbox

This block lets each of a set of processor cores post a 16-bit message, together with an interrupt, to any core in the set, itself included. Every core owns a window of two 32-bit registers. A write to the command register of a window can send a message from that window's core, acknowledge the message waiting at that core, or do both. The status register of a window shows whether a message is waiting, which core sent it and what data it carried. Each core has one level interrupt output, and that output follows its pending flag. Messages enter only through register writes; the block has no interrupt inputs.

Each core reaches the register map through its own request port, so several cores can issue accesses in the same cycle. Same-cycle writes that meet at one window, or that send to one destination, are settled by a fixed priority: the lower index wins. Words cross each port most significant byte first. A read returns its data in the cycle after the request.

Top module: `ipi_mailbox`

## Requirements
- R1: Core k's command register is at byte address 8k and its status register at 8k+4. An access whose address bits [1:0] are not zero has no effect and reads as zero.
- R2: A bus word is the register value with its bytes reversed. Register bits 7:0 travel on bus bits 31:24, and register bits 31:24 travel on bus bits 7:0.
- R3: A command write to window S with bit 30 (send) set, bits 29:16 = D (D below the core count) and bits 15:0 = X takes effect at the next clock edge. From then on, status D reads bit 30 = 1, bits 29:16 = S and bits 15:0 = X, and irq[D] is high.
- R4: A command write to window k with bit 31 (acknowledge) set clears core k's pending bit and drops irq[k] at the next edge. The source and data fields of core k keep their values.
- R5: When one write sets both acknowledge and send, the acknowledge is applied first. A core that sends to itself this way stays pending and holds the new source and data.
- R6: When two windows send to the same destination in one cycle, the lower-numbered window's message is stored and the other is dropped.
- R7: A message that reaches a core which is already pending replaces the source and data fields and leaves the core pending.
- R8: A send whose destination is at or above the core count has no effect. So do writes to status registers and accesses to windows at or above the core count.
- R9: A read request places its value on that port's rdata at the next edge, and rdata holds it until the next read. The value is the state from before any write in the same cycle. Command registers, status bit 31 and windows at or above the core count read as zero.
- R10: While reset is asserted, and until the reset is released internally two clocks later, every irq output is low and every pending, source and data field is zero.
- R11: irq[k] stays high until core k is acknowledged. Reads, and acknowledges of other cores, leave it unchanged.
- R12: When two ports write the same command register in one cycle, only the write from the lower-numbered port takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | NUM_CORES | Request strobe, one per port |
| bus_write | input | NUM_CORES | 1 = write, 0 = read, one per port |
| bus_addr | input | NUM_CORES*ADDR_W | Byte address, port p at slice p*ADDR_W |
| bus_wdata | input | NUM_CORES*32 | Write word per port, big-endian |
| bus_rdata | output | NUM_CORES*32 | Registered read word per port, big-endian |
| irq | output | NUM_CORES | Level interrupt per core |

## Verification
Several behaviours are checked by the assertions on every cycle. A routed send always raises the destination's interrupt and loads exactly the winning source index and data. A lone acknowledge always drops the interrupt. A core that receives neither a send nor an acknowledge holds its status bit for bit. Interrupts stay low while reset is active. The bench scenarios are the only way to show the parts that depend on the bus side. These are the address map, byte reversal, alignment filtering, the two priority orders, ack-before-send ordering, out-of-range destinations and the read-before-write view of rdata.

// File: rtl/ipimb_pkg.sv
package ipimb_pkg;
  localparam int REG_W  = 32;
  localparam int IDX_W  = 14;
  localparam int DATA_W = 16;

  typedef struct packed {
    logic              ack;
    logic              gen;
    logic [IDX_W-1:0]  dst;
    logic [DATA_W-1:0] data;
  } ctrl_t;

  typedef struct packed {
    logic              rsvd;
    logic              pend;
    logic [IDX_W-1:0]  src;
    logic [DATA_W-1:0] data;
  } stat_t;

  function automatic logic [REG_W-1:0] byte_rev(input logic [REG_W-1:0] v);
    logic [REG_W-1:0] r;
    for (int b = 0; b < REG_W/8; b++) r[b*8 +: 8] = v[REG_W-8-b*8 +: 8];
    return r;
  endfunction
endpackage

// File: rtl/ipimb_rst_sync.sv
module ipimb_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ok
);
  logic meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      rst_ok <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      rst_ok <= meta_q;
    end
  end
endmodule

// File: rtl/ipimb_wr_merge.sv
module ipimb_wr_merge
  import ipimb_pkg::*;
#(
  parameter int NUM_CORES  = 4,
  parameter int ADDR_W     = 8,
  parameter bit BIG_ENDIAN = 1'b1
) (
  input  logic [NUM_CORES-1:0]         bus_valid,
  input  logic [NUM_CORES-1:0]         bus_write,
  input  logic [NUM_CORES*ADDR_W-1:0]  bus_addr,
  input  logic [NUM_CORES*REG_W-1:0]   bus_wdata,
  output logic [NUM_CORES-1:0]         win_wr,
  output ctrl_t [NUM_CORES-1:0]        win_word
);
  localparam int WIN_W = ADDR_W - 3;

  logic  [NUM_CORES-1:0]            ctrl_hit;
  logic  [NUM_CORES-1:0][WIN_W-1:0] port_win;
  ctrl_t [NUM_CORES-1:0]            port_word;

  for (genvar p = 0; p < NUM_CORES; p++) begin : g_port
    assign port_win[p] = bus_addr[p*ADDR_W+3 +: WIN_W];
    assign ctrl_hit[p] = bus_valid[p] & bus_write[p] &
                         (bus_addr[p*ADDR_W +: 3] == 3'b000);
    if (BIG_ENDIAN) begin : g_be
      assign port_word[p] = ctrl_t'(byte_rev(bus_wdata[p*REG_W +: REG_W]));
    end else begin : g_le
      assign port_word[p] = ctrl_t'(bus_wdata[p*REG_W +: REG_W]);
    end
  end

  // Highest port scanned first so the lowest matching port is written last.
  always_comb begin
    win_wr   = '0;
    win_word = '0;
    for (int w = 0; w < NUM_CORES; w++) begin
      for (int p = NUM_CORES - 1; p >= 0; p--) begin
        if (ctrl_hit[p] && (port_win[p] == WIN_W'(w))) begin
          win_wr[w]   = 1'b1;
          win_word[w] = port_word[p];
        end
      end
    end
  end
endmodule

// File: rtl/ipimb_route.sv
module ipimb_route
  import ipimb_pkg::*;
#(
  parameter int NUM_CORES = 4
) (
  input  logic  [NUM_CORES-1:0]             win_wr,
  input  ctrl_t [NUM_CORES-1:0]             win_word,
  output logic  [NUM_CORES-1:0]             ack_vec,
  output logic  [NUM_CORES-1:0]             send_vec,
  output logic  [NUM_CORES-1:0][IDX_W-1:0]  send_src,
  output logic  [NUM_CORES-1:0][DATA_W-1:0] send_data
);
  always_comb begin
    for (int s = 0; s < NUM_CORES; s++) ack_vec[s] = win_wr[s] & win_word[s].ack;
  end

  // Per destination, the lowest-numbered sending window wins.
  always_comb begin
    send_vec  = '0;
    send_src  = '0;
    send_data = '0;
    for (int d = 0; d < NUM_CORES; d++) begin
      for (int s = NUM_CORES - 1; s >= 0; s--) begin
        if (win_wr[s] && win_word[s].gen && (win_word[s].dst == IDX_W'(d))) begin
          send_vec[d]  = 1'b1;
          send_src[d]  = IDX_W'(s);
          send_data[d] = win_word[s].data;
        end
      end
    end
  end
endmodule

// File: rtl/ipimb_slot.sv
module ipimb_slot
  import ipimb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_ok,
  input  logic              ack,
  input  logic              send,
  input  logic [IDX_W-1:0]  in_src,
  input  logic [DATA_W-1:0] in_data,
  output logic              pend_q,
  output logic [IDX_W-1:0]  src_q,
  output logic [DATA_W-1:0] data_q
);
  logic              pend_n;
  logic [IDX_W-1:0]  src_n;
  logic [DATA_W-1:0] data_n;
  logic              upd_en;

  // Acknowledge first, then a new message.
  always_comb begin
    pend_n = pend_q;
    src_n  = src_q;
    data_n = data_q;
    if (ack) pend_n = 1'b0;
    if (send) begin
      pend_n = 1'b1;
      src_n  = in_src;
      data_n = in_data;
    end
    upd_en = ack | send;
  end

  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok) begin
      pend_q <= 1'b0;
      src_q  <= '0;
      data_q <= '0;
    end else if (upd_en) begin
      pend_q <= pend_n;
      src_q  <= src_n;
      data_q <= data_n;
    end
  end
endmodule

// File: rtl/ipi_mailbox.sv
module ipi_mailbox
  import ipimb_pkg::*;
#(
  parameter int NUM_CORES  = 4,
  parameter int ADDR_W     = 8,
  parameter bit BIG_ENDIAN = 1'b1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_CORES-1:0]        bus_valid,
  input  logic [NUM_CORES-1:0]        bus_write,
  input  logic [NUM_CORES*ADDR_W-1:0] bus_addr,
  input  logic [NUM_CORES*REG_W-1:0]  bus_wdata,
  output logic [NUM_CORES*REG_W-1:0]  bus_rdata,
  output logic [NUM_CORES-1:0]        irq
);
  localparam int WIN_W = ADDR_W - 3;

  logic                             rst_ok;
  logic  [NUM_CORES-1:0]            win_wr;
  ctrl_t [NUM_CORES-1:0]            win_word;
  logic  [NUM_CORES-1:0]            ack_vec;
  logic  [NUM_CORES-1:0]            send_vec;
  logic  [NUM_CORES-1:0][IDX_W-1:0]  send_src;
  logic  [NUM_CORES-1:0][DATA_W-1:0] send_data;
  logic  [NUM_CORES-1:0]            pend;
  logic  [NUM_CORES-1:0][IDX_W-1:0]  stat_src;
  logic  [NUM_CORES-1:0][DATA_W-1:0] stat_data;
  logic  [NUM_CORES-1:0][REG_W-1:0]  rd_val;
  logic  [NUM_CORES-1:0][REG_W-1:0]  rdata_n;
  logic  [NUM_CORES-1:0][REG_W-1:0]  rdata_q;
  logic  [NUM_CORES-1:0]            rd_en;

  ipimb_rst_sync u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_ok (rst_ok)
  );

  ipimb_wr_merge #(
    .NUM_CORES  (NUM_CORES),
    .ADDR_W     (ADDR_W),
    .BIG_ENDIAN (BIG_ENDIAN)
  ) u_merge (
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .win_wr    (win_wr),
    .win_word  (win_word)
  );

  ipimb_route #(.NUM_CORES(NUM_CORES)) u_route (
    .win_wr    (win_wr),
    .win_word  (win_word),
    .ack_vec   (ack_vec),
    .send_vec  (send_vec),
    .send_src  (send_src),
    .send_data (send_data)
  );

  for (genvar k = 0; k < NUM_CORES; k++) begin : g_slot
    ipimb_slot u_slot (
      .clk     (clk),
      .rst_ok  (rst_ok),
      .ack     (ack_vec[k]),
      .send    (send_vec[k]),
      .in_src  (send_src[k]),
      .in_data (send_data[k]),
      .pend_q  (pend[k]),
      .src_q   (stat_src[k]),
      .data_q  (stat_data[k])
    );
  end

  assign irq = pend;

  // Read select: only aligned status addresses inside the map return data.
  always_comb begin
    for (int p = 0; p < NUM_CORES; p++) begin
      rd_val[p] = '0;
      rd_en[p]  = bus_valid[p] & ~bus_write[p];
      for (int k = 0; k < NUM_CORES; k++) begin
        if ((bus_addr[p*ADDR_W +: 3] == 3'b100) &&
            (bus_addr[p*ADDR_W+3 +: WIN_W] == WIN_W'(k))) begin
          rd_val[p] = {1'b0, pend[k], stat_src[k], stat_data[k]};
        end
      end
      rdata_n[p] = rd_en[p] ? rd_val[p] : rdata_q[p];
    end
  end

  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok) rdata_q <= '0;
    else         rdata_q <= rdata_n;
  end

  for (genvar p = 0; p < NUM_CORES; p++) begin : g_rd
    if (BIG_ENDIAN) begin : g_be
      assign bus_rdata[p*REG_W +: REG_W] = byte_rev(rdata_q[p]);
    end else begin : g_le
      assign bus_rdata[p*REG_W +: REG_W] = rdata_q[p];
    end
  end
endmodule

// File: rtl/ipimb_chk.sv
module ipimb_chk
  import ipimb_pkg::*;
#(
  parameter int NUM_CORES = 4
) (
  input logic                             clk,
  input logic                             rst_ok,
  input logic [NUM_CORES-1:0]             irq,
  input logic [NUM_CORES-1:0]             ack_vec,
  input logic [NUM_CORES-1:0]             send_vec,
  input logic [NUM_CORES-1:0][IDX_W-1:0]  send_src,
  input logic [NUM_CORES-1:0][DATA_W-1:0] send_data,
  input logic [NUM_CORES-1:0][IDX_W-1:0]  stat_src,
  input logic [NUM_CORES-1:0][DATA_W-1:0] stat_data
);
  // R10
  reset_quiet_chk: assert property (@(posedge clk) !rst_ok |-> irq == '0);

  for (genvar k = 0; k < NUM_CORES; k++) begin : g_core
    // R3
    send_raise_chk: assert property (@(posedge clk) disable iff (!rst_ok)
      send_vec[k] |=> irq[k]);
    // R3
    send_load_chk: assert property (@(posedge clk) disable iff (!rst_ok)
      send_vec[k] |=> (stat_src[k] == $past(send_src[k])) && (stat_data[k] == $past(send_data[k])));
    // R6
    send_src_range_chk: assert property (@(posedge clk) disable iff (!rst_ok)
      send_vec[k] |-> send_src[k] < IDX_W'(NUM_CORES));
    // R4
    ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_ok)
      ack_vec[k] && !send_vec[k] |=> !irq[k] && $stable(stat_data[k]));
    // R11
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_ok)
      !ack_vec[k] && !send_vec[k] |=> $stable(irq[k]) && $stable(stat_src[k]) && $stable(stat_data[k]));
  end
endmodule

bind ipi_mailbox ipimb_chk #(.NUM_CORES(NUM_CORES)) u_chk (
  .clk       (clk),
  .rst_ok    (rst_ok),
  .irq       (irq),
  .ack_vec   (ack_vec),
  .send_vec  (send_vec),
  .send_src  (send_src),
  .send_data (send_data),
  .stat_src  (stat_src),
  .stat_data (stat_data)
);

// File: tb/ipi_mailbox_tb.sv
`timescale 1ns/1ps
module ipi_mailbox_tb;
  localparam int N  = 4;
  localparam int AW = 8;

  logic            clk = 1'b0;
  logic            rst_n;
  logic [N-1:0]    valid;
  logic [N-1:0]    write;
  logic [N*AW-1:0] addr;
  logic [N*32-1:0] wdata;
  logic [N*32-1:0] rdata;
  logic [N-1:0]    irq;

  int nchk = 0;
  int nerr = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  ipi_mailbox #(.NUM_CORES(N), .ADDR_W(AW), .BIG_ENDIAN(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_valid(valid), .bus_write(write),
    .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata), .irq(irq)
  );

  function automatic logic [31:0] rev(input logic [31:0] v);
    return {v[7:0], v[15:8], v[23:16], v[31:24]};
  endfunction

  function automatic logic [31:0] cmd(input bit a, input bit g, input logic [13:0] d, input logic [15:0] x);
    return {a, g, d, x};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    valid = '0; write = '0; addr = '0; wdata = '0;
  endtask

  task automatic put(input int p, input logic [7:0] a, input logic [31:0] v, input bit wr);
    valid[p] = 1'b1;
    write[p] = wr;
    addr[p*AW +: AW] = a;
    wdata[p*32 +: 32] = rev(v);
  endtask

  task automatic wr1(input int p, input logic [7:0] a, input logic [31:0] v);
    @(negedge clk); put(p, a, v, 1'b1);
    @(negedge clk); idle();
  endtask

  task automatic wr2(input int p1, input logic [7:0] a1, input logic [31:0] v1,
                     input int p2, input logic [7:0] a2, input logic [31:0] v2);
    @(negedge clk); put(p1, a1, v1, 1'b1); put(p2, a2, v2, 1'b1);
    @(negedge clk); idle();
  endtask

  task automatic rd(input int p, input logic [7:0] a, output logic [31:0] val, output logic [31:0] raw);
    @(negedge clk); put(p, a, 32'h0, 1'b0);
    @(negedge clk); idle();
    raw = rdata[p*32 +: 32];
    val = rev(raw);
  endtask

  task automatic t_reset();
    logic [31:0] v, r;
    rst_n = 1'b0; idle();
    repeat (3) @(negedge clk);
    check("R10 irq in reset", {28'h0, irq}, 32'h0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R10 irq after reset", {28'h0, irq}, 32'h0);
    rd(0, 8'h04, v, r); check("R10 status0 cleared", v, 32'h0);
    rd(1, 8'h1C, v, r); check("R10 status3 cleared", v, 32'h0);
  endtask

  task automatic t_send();
    logic [31:0] v, r;
    wr1(0, 8'h08, cmd(0, 1, 14'd2, 16'hBEEF));
    check("R3 irq after send", {28'h0, irq}, 32'h4);
    rd(3, 8'h14, v, r);
    check("R3 status2 fields", v, 32'h4001_BEEF);
    check("R2 byte order of read", r, 32'hEFBE_0140);
    rd(1, 8'h10, v, r); check("R9 command reads zero", v, 32'h0);
    wr1(1, 8'h01, cmd(0, 1, 14'd3, 16'h0001));
    check("R1 misaligned write ignored", {28'h0, irq}, 32'h4);
  endtask

  task automatic t_ack();
    logic [31:0] v, r;
    wr1(2, 8'h10, cmd(1, 0, 14'd0, 16'h0));
    check("R4 irq after ack", {28'h0, irq}, 32'h0);
    rd(2, 8'h14, v, r); check("R4 fields kept", v, 32'h0001_BEEF);
  endtask

  task automatic t_ignored();
    logic [31:0] v, r;
    wr1(0, 8'h18, cmd(0, 1, 14'd5, 16'h1234));
    check("R8 dst out of range", {28'h0, irq}, 32'h0);
    wr1(0, 8'h0C, 32'h4000_0001);
    check("R8 status write irq", {28'h0, irq}, 32'h0);
    rd(0, 8'h0C, v, r); check("R8 status write value", v, 32'h0);
    wr1(0, 8'h30, cmd(0, 1, 14'd1, 16'h4321));
    check("R8 window beyond map", {28'h0, irq}, 32'h0);
    rd(0, 8'h34, v, r); check("R9 window beyond map reads zero", v, 32'h0);
  endtask

  task automatic t_collide();
    logic [31:0] v, r;
    wr2(1, 8'h18, cmd(0, 1, 14'd0, 16'h3333), 0, 8'h10, cmd(0, 1, 14'd0, 16'h2222));
    check("R6 irq after collision", {28'h0, irq}, 32'h1);
    rd(0, 8'h04, v, r); check("R6 lower sender wins", v, 32'h4002_2222);
    wr1(3, 8'h08, cmd(0, 1, 14'd0, 16'h1111));
    rd(0, 8'h04, v, r); check("R7 overwrite while pending", v, 32'h4001_1111);
  endtask

  task automatic t_ackgen();
    logic [31:0] v, r;
    wr1(0, 8'h00, cmd(1, 1, 14'd0, 16'h5555));
    check("R5 self send stays pending", {28'h0, irq}, 32'h1);
    rd(0, 8'h04, v, r); check("R5 self send fields", v, 32'h4000_5555);
    wr1(0, 8'h00, cmd(1, 1, 14'd1, 16'h6666));
    check("R5 ack own then send other", {28'h0, irq}, 32'h2);
    rd(1, 8'h0C, v, r); check("R5 status1", v, 32'h4000_6666);
  endtask

  task automatic t_hold();
    logic [31:0] v, r;
    wr1(2, 8'h10, cmd(0, 1, 14'd3, 16'h7777));
    check("R11 two pending", {28'h0, irq}, 32'hA);
    wr1(0, 8'h00, cmd(1, 0, 14'd0, 16'h0));
    check("R11 other ack leaves irq", {28'h0, irq}, 32'hA);
    rd(3, 8'h0C, v, r);
    check("R11 read leaves irq", {28'h0, irq}, 32'hA);
  endtask

  task automatic t_same_window();
    logic [31:0] v, r;
    wr2(3, 8'h10, cmd(0, 1, 14'd2, 16'hCCCC), 1, 8'h10, cmd(0, 1, 14'd2, 16'hAAAA));
    check("R12 irq", {28'h0, irq}, 32'hE);
    rd(0, 8'h14, v, r); check("R12 lower port wins", v, 32'h4002_AAAA);
    @(negedge clk); put(0, 8'h10, cmd(1, 0, 14'd0, 16'h0), 1'b1); put(1, 8'h14, 32'h0, 1'b0);
    @(negedge clk); idle();
    check("R9 read sees pre-write state", rev(rdata[32 +: 32]), 32'h4002_AAAA);
    check("R4 same-cycle ack applied", {28'h0, irq}, 32'hA);
  endtask

  initial begin
    rst_n = 1'b0;
    idle();
    t_reset();
    t_send();
    t_ack();
    t_ignored();
    t_collide();
    t_ackgen();
    t_hold();
    t_same_window();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nchk++; nerr++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end
endmodule